// File: doc/BRIEF.md
# Three-Zone Magnetic Field Result Encoder

This block sits between two field comparators, one watching a positive threshold and one watching a negative threshold, and the two active-low output pins of a pulsed field sensor. A timing generator raises a one-cycle sample strobe at the end of each measurement window. On that strobe the block captures both comparator decisions and encodes them into a 2-bit active-low code. The code then stays on the pins through the power-gated standby interval that follows. A low-supply condition claims the fourth code value and takes priority over any stored result.

Each comparator uses its own last decision to choose its reference level. The block therefore also drives one threshold-select line per comparator. A comparator that has detected its field is given the looser release level, and keeps it until a later sample reports that the field has dropped back. The analog comparison, the supply detector and the level shifters are outside this block.

Top module: `field_zone_encoder`

## Requirements
- R1: A valid sample with only the positive comparator active gives out1_n=0, out2_n=1 one clock after the strobe edge.
- R2: A valid sample with only the negative comparator active gives out1_n=1, out2_n=0 one clock after the strobe edge.
- R3: A valid sample with neither comparator active gives the near-zero code out1_n=1, out2_n=1.
- R4: A valid sample with both comparators active, which cannot happen physically, also gives the near-zero code 1,1.
- R5: While low_supply is high, the outputs read 0,0 one clock later whatever was stored, and the stored decisions are cleared.
- R6: Between strobes the comparator inputs are ignored, and outputs and selects keep their last values.
- R7: When low_supply is high or ready is low, the outputs show 0,0 and stay there until the first strobe taken with ready=1 and low_supply=0. A strobe that arrives while ready=0 is ignored.
- R8: thr_sel_pos equals the last captured positive decision and thr_sel_neg the last captured negative decision, where 1 selects the release level and 0 the entry level. Both return to 0 under low supply or not-ready.
- R9: After reset the outputs are 0,0 and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_stb | input | 1 | One-cycle strobe at the end of the measure phase |
| cmp_pos | input | 1 | Positive-threshold comparator decision |
| cmp_neg | input | 1 | Negative-threshold comparator decision |
| low_supply | input | 1 | Supply below its operating limit |
| ready | input | 1 | Regulator and reference have settled |
| out1_n | output | 1 | Active-low strong-positive / low-supply pin |
| out2_n | output | 1 | Active-low strong-negative / low-supply pin |
| thr_sel_pos | output | 1 | Positive comparator reference select (1 = release) |
| thr_sel_neg | output | 1 | Negative comparator reference select (1 = release) |

## Verification
A stuck or stale decision register shows up at the pins one clock after the strobe that should have changed it. The wrong code and the wrong threshold select appear on the same cycle. A missing valid flag shows up on the first strobe after a low-supply event: the pins leave 0,0 too early or fail to leave it at all. Leakage of the comparator inputs between strobes shows up one clock after any such toggle, because the outputs then lose their held value.

// File: rtl/fze_pkg.sv
package fze_pkg;
  typedef struct packed {
    logic pos;
    logic neg;
  } fze_dec_t;

  localparam logic [1:0] CODE_LOWSUP = 2'b00;
  localparam logic [1:0] CODE_POS    = 2'b01;
  localparam logic [1:0] CODE_NEG    = 2'b10;
  localparam logic [1:0] CODE_ZERO   = 2'b11;

  // {out1_n,out2_n} for a captured decision pair
  function automatic logic [1:0] fze_encode(input fze_dec_t d, input logic valid);
    if (!valid)             return CODE_LOWSUP;
    else if (d.pos && !d.neg) return CODE_POS;
    else if (d.neg && !d.pos) return CODE_NEG;
    else                    return CODE_ZERO;
  endfunction
endpackage

// File: rtl/fze_capture.sv
module fze_capture
  import fze_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     capture_en,
  input  logic     clear_en,
  input  fze_dec_t raw,
  output fze_dec_t dec_q,
  output logic     valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q   <= '0;
      valid_q <= 1'b0;
    end else if (clear_en) begin
      dec_q   <= '0;
      valid_q <= 1'b0;
    end else if (capture_en) begin
      dec_q   <= raw;
      valid_q <= 1'b1;
    end
  end

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (!valid_q && dec_q == '0));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_en && !capture_en) |=> ($stable(dec_q) && $stable(valid_q)));
endmodule

// File: rtl/fze_hyst_sel.sv
module fze_hyst_sel
  import fze_pkg::*;
(
  input  fze_dec_t dec_q,
  output logic     sel_pos,
  output logic     sel_neg
);
  // Each comparator's reference follows its own last decision.
  assign sel_pos = dec_q.pos;
  assign sel_neg = dec_q.neg;
endmodule

// File: rtl/field_zone_encoder.sv
module field_zone_encoder
  import fze_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sample_stb,
  input  logic cmp_pos,
  input  logic cmp_neg,
  input  logic low_supply,
  input  logic ready,
  output logic out1_n,
  output logic out2_n,
  output logic thr_sel_pos,
  output logic thr_sel_neg
);
  logic     clear_en;
  logic     capture_en;
  fze_dec_t raw;
  fze_dec_t dec_q;
  logic     valid_q;
  logic [1:0] code;

  assign clear_en   = low_supply || !ready;
  assign capture_en = sample_stb && !clear_en;
  assign raw        = '{pos: cmp_pos, neg: cmp_neg};

  fze_capture u_cap (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .clear_en(clear_en),
    .raw(raw), .dec_q(dec_q), .valid_q(valid_q)
  );

  fze_hyst_sel u_sel (.dec_q(dec_q), .sel_pos(thr_sel_pos), .sel_neg(thr_sel_neg));

  assign code   = fze_encode(dec_q, valid_q);
  assign out1_n = code[1];
  assign out2_n = code[0];

  p_lowsup_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    low_supply |=> (!out1_n && !out2_n && !thr_sel_pos && !thr_sel_neg));
  p_pos_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && cmp_pos && !cmp_neg) |=> (!out1_n && out2_n));
  p_neg_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && cmp_neg && !cmp_pos) |=> (out1_n && !out2_n));
  p_both_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_en && cmp_neg && cmp_pos) |=> (out1_n && out2_n));
  p_sel_vs_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_sel_pos && !thr_sel_neg) |-> (!out1_n && out2_n));
  p_stb_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready) |=> (!out1_n && !out2_n));
endmodule

// File: tb/tb_field_zone_encoder.sv
module tb_field_zone_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0, cmp_pos = 1'b0, cmp_neg = 1'b0;
  logic low_supply = 1'b0, ready = 1'b0;
  logic out1_n, out2_n, thr_sel_pos, thr_sel_neg;
  int   n_run = 0, n_fail = 0;
  logic m_pos = 1'b0, m_neg = 1'b0, m_valid = 1'b0;

  always #10 clk = ~clk;

  field_zone_encoder dut (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .cmp_pos(cmp_pos),
    .cmp_neg(cmp_neg), .low_supply(low_supply), .ready(ready),
    .out1_n(out1_n), .out2_n(out2_n), .thr_sel_pos(thr_sel_pos), .thr_sel_neg(thr_sel_neg)
  );

  function automatic logic [1:0] exp_pins(input logic v, input logic p, input logic n);
    if (!v) return 2'b00;
    if (p == n) return 2'b11;
    return p ? 2'b01 : 2'b10;
  endfunction

  function automatic string req_of(input logic v, input logic p, input logic n);
    if (!v) return "R5/R7";
    if (p && n) return "R4";
    if (p) return "R1";
    if (n) return "R2";
    return "R3";
  endfunction

  task automatic check_now(input string tag);
    logic [1:0] e;
    e = exp_pins(m_valid, m_pos, m_neg);
    n_run++;
    if ({out1_n, out2_n} !== e || thr_sel_pos !== m_pos || thr_sel_neg !== m_neg) begin
      n_fail++;
      $display("FAIL %s/%s(R8,R6): pins=%b sel=%b%b expected pins=%b sel=%b%b",
               tag, req_of(m_valid, m_pos, m_neg), {out1_n, out2_n},
               thr_sel_pos, thr_sel_neg, e, m_pos, m_neg);
    end
  endtask

  // drive at negedge, model updates on the next posedge, check at following negedge
  task automatic step(input logic s, input logic p, input logic n,
                      input logic lo, input logic rd, input string tag);
    sample_stb = s; cmp_pos = p; cmp_neg = n; low_supply = lo; ready = rd;
    @(posedge clk);
    if (lo || !rd) begin m_valid = 1'b0; m_pos = 1'b0; m_neg = 1'b0; end
    else if (s) begin m_valid = 1'b1; m_pos = p; m_neg = n; end
    @(negedge clk);
    check_now(tag);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: expected finish before timeout");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    check_now("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_now("R9 after release");
    // R7: strobe while not ready ignored
    step(1, 1, 0, 0, 0, "R7 strobe not ready");
    step(0, 1, 0, 0, 1, "R7 still no valid sample");
    step(1, 1, 0, 0, 1, "R1 positive");
    step(0, 0, 1, 0, 1, "R6 ignored between strobes");
    step(1, 0, 1, 0, 1, "R2 negative");
    step(1, 0, 0, 0, 1, "R3 near zero");
    step(1, 1, 1, 0, 1, "R4 both active");
    step(1, 1, 0, 0, 1, "R8 select pos release");
    step(0, 1, 0, 1, 1, "R5 low supply override");
    step(0, 1, 0, 0, 1, "R7 held after low supply");
    step(1, 0, 1, 1, 1, "R5 strobe during low supply");
    step(1, 0, 1, 0, 1, "R7 first valid after low supply");
    for (int i = 0; i < 3000; i++) begin
      logic s, p, n, lo, rd;
      s  = ($urandom % 4) == 0;
      p  = $urandom % 2;
      n  = ($urandom % 3) == 0;
      lo = ($urandom % 20) == 0;
      rd = ($urandom % 30) != 0;
      step(s, p, n, lo, rd, "random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule